// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of nonmaskable trap request lines and a larger set of maskable peripheral request lines. It presents the CPU with a single request, the level of the winning source, the winning vector number and the program address to fetch that vector from. Vector numbers 0 to 7 belong to the traps. Maskable source `i` owns vector `8 + i`, so the default build has 126 vector slots.

Arbitration has two tiers. The first tier is the level: traps always rank above every user level. The second tier is the position in the table: among equal levels, the lower vector number wins.

Each maskable source has an enable and a 3-bit priority. A request pulse latches a pending flag, and an acknowledge from the CPU retires the flag of the source currently presented. A select input moves every vector fetch into a second table of identical layout, placed directly after the first. The result is registered, so every source sees the same latency from request to vector.

Top module: `vic_core`

## Requirements
- R1: While reset is low and on the first edge after it, `cpu_req` is 0 and `vec_idx`, `vec_addr` and `req_level` are 0. Whenever `cpu_req` is 0, those three outputs are 0.
- R2: A pending trap is presented ahead of any maskable source, whatever the enables and `cpu_prio` are.
- R3: Among several pending traps, the one with the lowest vector number is presented first.
- R4: A maskable source is presented only if it is pending, its enable is 1 and its priority is strictly greater than `cpu_prio`. A priority of 0 is never presented.
- R5: A maskable source with a higher priority is presented before one with a lower priority, even when its vector number is larger.
- R6: Among maskable sources of equal priority, the lower vector number (vector of source i = 8 + i) is presented first.
- R7: With `alt_sel` = 0, `vec_addr` = 0x000004 + 2 × `vec_idx`.
- R8: With `alt_sel` = 1, `vec_addr` = 0x000100 + 2 × `vec_idx`. This applies to traps and maskable sources alike.
- R9: `req_level` is 15 − t for trap t, and equals the source's own priority for a maskable source.
- R10: `ack` while `cpu_req` = 1 clears the pending flag of the presented vector. The next candidate, or idle, appears after that same edge. `ack` while idle has no effect.
- R11: A request pulse sampled at a clock edge is visible on the outputs right after that edge, with the same latency for every vector number.
- R12: A new request pulse on the vector being acknowledged, in the same cycle as the acknowledge, keeps that vector pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 8 | Trap request pulses; bit t is vector t |
| irq_req | input | 118 | Maskable request pulses; bit i is vector 8+i |
| irq_en | input | 118 | Per-source enable |
| irq_prio | input | 354 | Per-source 3-bit priority; source i at bits [3i+2:3i] |
| cpu_prio | input | 3 | Current CPU priority |
| alt_sel | input | 1 | Selects the second vector table |
| ack | input | 1 | CPU accepts the presented vector |
| cpu_req | output | 1 | Request to the CPU |
| vec_idx | output | 7 | Presented vector number |
| vec_addr | output | 24 | Fetch address of the presented vector |
| req_level | output | 4 | Level of the presented vector |

## Verification
The bound checker checks the following on every cycle:
- idle outputs are quiet,
- the address follows the selected table map,
- trap levels are correct,
- a presented maskable source lies above the CPU priority sampled at the previous edge,
- a trap pulse always wins on the next cycle.

Some behaviour shows only through the bench's scenarios, since it depends on which vectors are pending:
- the ordering between several pending sources,
- retiring a vector through the acknowledge,
- the set-over-clear case,
- a source masked by its enable or priority and later released.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int          NUM_TRAPS    = 8,
  parameter int          NUM_SRC      = 118,
  parameter int          PRIO_W       = 3,
  parameter int          ADDR_W       = 24,
  parameter logic [23:0] TABLE_BASE   = 24'h000004,
  parameter int          ENTRY_STRIDE = 2,
  localparam int NUM_VEC    = NUM_TRAPS + NUM_SRC,
  localparam int IDX_W      = $clog2(NUM_VEC),
  localparam int LVL_W      = $clog2((1 << PRIO_W) + NUM_TRAPS),
  localparam int ALT_OFFSET = ENTRY_STRIDE * NUM_VEC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TRAPS-1:0]       trap_req,
  input  logic [NUM_SRC-1:0]         irq_req,
  input  logic [NUM_SRC-1:0]         irq_en,
  input  logic [NUM_SRC*PRIO_W-1:0]  irq_prio,
  input  logic [PRIO_W-1:0]          cpu_prio,
  input  logic                       alt_sel,
  input  logic                       ack,
  output logic                       cpu_req,
  output logic [IDX_W-1:0]           vec_idx,
  output logic [ADDR_W-1:0]          vec_addr,
  output logic [LVL_W-1:0]           req_level
);

  localparam int TOP_LVL = (1 << PRIO_W) + NUM_TRAPS - 1;

  logic [NUM_VEC-1:0] pend_q, pend_d, clr_vec;
  logic [LVL_W-1:0]   cand_lvl [NUM_VEC];
  logic [LVL_W-1:0]   win_lvl;
  logic [IDX_W-1:0]   win_idx;
  logic [ADDR_W-1:0]  win_addr;

  assign clr_vec = (ack && cpu_req) ? ({{(NUM_VEC-1){1'b0}}, 1'b1} << vec_idx) : '0;
  assign pend_d  = (pend_q & ~clr_vec) | {irq_req, trap_req};

  for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
    assign cand_lvl[t] = pend_d[t] ? LVL_W'(TOP_LVL - t) : '0;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [PRIO_W-1:0] p;
    assign p = irq_prio[s*PRIO_W +: PRIO_W];
    assign cand_lvl[NUM_TRAPS+s] =
      (pend_d[NUM_TRAPS+s] && irq_en[s] && (p > cpu_prio)) ? LVL_W'(p) : '0;
  end

  // descending scan with >= so ties settle on the lowest vector number
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (cand_lvl[v] != '0 && cand_lvl[v] >= win_lvl) begin
        win_lvl = cand_lvl[v];
        win_idx = IDX_W'(v);
      end
    end
  end

  assign win_addr = TABLE_BASE
                  + ADDR_W'(ENTRY_STRIDE) * ADDR_W'(win_idx)
                  + (alt_sel ? ADDR_W'(ALT_OFFSET) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cpu_req   <= 1'b0;
      vec_idx   <= '0;
      vec_addr  <= '0;
      req_level <= '0;
    end else begin
      pend_q    <= pend_d;
      cpu_req   <= (win_lvl != '0);
      vec_idx   <= win_idx;
      vec_addr  <= (win_lvl != '0) ? win_addr : '0;
      req_level <= win_lvl;
    end
  end

endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int          NUM_TRAPS    = 8,
  parameter int          NUM_SRC      = 118,
  parameter int          PRIO_W       = 3,
  parameter int          ADDR_W       = 24,
  parameter logic [23:0] TABLE_BASE   = 24'h000004,
  parameter int          ENTRY_STRIDE = 2,
  localparam int NUM_VEC = NUM_TRAPS + NUM_SRC,
  localparam int IDX_W   = $clog2(NUM_VEC),
  localparam int LVL_W   = $clog2((1 << PRIO_W) + NUM_TRAPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TRAPS-1:0] trap_req,
  input logic [PRIO_W-1:0]    cpu_prio,
  input logic                 alt_sel,
  input logic                 cpu_req,
  input logic [IDX_W-1:0]     vec_idx,
  input logic [ADDR_W-1:0]    vec_addr,
  input logic [LVL_W-1:0]     req_level
);

  localparam int TOP_LVL = (1 << PRIO_W) + NUM_TRAPS - 1;
  localparam int ALT_OFF = ENTRY_STRIDE * NUM_VEC;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (vec_idx == '0 && vec_addr == '0 && req_level == '0));

  p_trap_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(|trap_req)) |-> (cpu_req && int'(vec_idx) < NUM_TRAPS));

  p_user_above_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && int'(vec_idx) >= NUM_TRAPS)
      |-> (int'(req_level) > int'($past(cpu_prio)) && int'(req_level) < (1 << PRIO_W)));

  p_addr_primary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !$past(alt_sel))
      |-> (int'(vec_addr) == int'(TABLE_BASE) + ENTRY_STRIDE * int'(vec_idx)));

  p_addr_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && $past(alt_sel))
      |-> (int'(vec_addr) == int'(TABLE_BASE) + ALT_OFF + ENTRY_STRIDE * int'(vec_idx)));

  p_trap_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && int'(vec_idx) < NUM_TRAPS) |-> (int'(req_level) == TOP_LVL - int'(vec_idx)));

endmodule

bind vic_core vic_core_chk #(
  .NUM_TRAPS(NUM_TRAPS), .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
  .TABLE_BASE(TABLE_BASE), .ENTRY_STRIDE(ENTRY_STRIDE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .cpu_prio(cpu_prio),
  .alt_sel(alt_sel), .cpu_req(cpu_req), .vec_idx(vec_idx),
  .vec_addr(vec_addr), .req_level(req_level)
);

// File: tb/vic_core_tb_top.sv
module vic_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int NS = 118;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NT-1:0] trap_req = '0;
  logic [NS-1:0] irq_req = '0;
  logic [NS-1:0] irq_en = '0;
  logic [NS*3-1:0] irq_prio = '0;
  logic [2:0]    cpu_prio = '0;
  logic          alt_sel = 0;
  logic          ack = 0;
  logic          cpu_req;
  logic [6:0]    vec_idx;
  logic [23:0]   vec_addr;
  logic [3:0]    req_level;

  int checks = 0;
  int errors = 0;

  typedef struct { string tag; bit req; int idx; int addr; int lvl; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_core dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
    .alt_sel(alt_sel), .ack(ack), .cpu_req(cpu_req), .vec_idx(vec_idx),
    .vec_addr(vec_addr), .req_level(req_level)
  );

  function automatic int ea(int idx, bit alt);
    return 4 + 2*idx + (alt ? 252 : 0);
  endfunction

  task automatic cfg(int s, bit en, int p);
    irq_en[s] = en;
    irq_prio[s*3 +: 3] = 3'(p);
  endtask

  // driver: lets one edge pass, then queues what must be visible after it
  task automatic expect_tick(string tag, bit r, int i, int l);
    exp_t e;
    @(posedge clk);
    #1;
    e.tag = tag; e.req = r; e.idx = r ? i : 0; e.lvl = r ? l : 0;
    e.addr = r ? ea(i, alt_sel) : 0;
    sb.push_back(e);
    @(negedge clk);
    irq_req = '0; trap_req = '0; ack = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (cpu_req !== e.req || int'(vec_idx) != e.idx ||
            int'(vec_addr) != e.addr || int'(req_level) != e.lvl) begin
          errors++;
          $display("FAIL %s: got req=%0d idx=%0d addr=%0h lvl=%0d exp req=%0d idx=%0d addr=%0h lvl=%0d",
                   e.tag, cpu_req, vec_idx, vec_addr, req_level, e.req, e.idx, e.addr, e.lvl);
        end
      end
    end
  end

  task automatic scenarios();
    @(negedge clk);
    checks++;
    if (cpu_req !== 1'b0 || vec_idx != 0 || vec_addr != 0 || req_level != 0) begin
      errors++;
      $display("FAIL R1 in reset: req=%0d idx=%0d addr=%0h lvl=%0d exp all 0",
               cpu_req, vec_idx, vec_addr, req_level);
    end
    rst_n = 1;
    expect_tick("R1 first edge idle", 0, 0, 0);

    // R4 / R11 basic presentation and holding
    cfg(5, 1, 3); irq_req[5] = 1;
    expect_tick("R11 src5 seen next edge", 1, 13, 3);
    expect_tick("R4 src5 held without ack", 1, 13, 3);
    ack = 1;
    expect_tick("R10 ack retires src5", 0, 0, 0);
    ack = 1;
    expect_tick("R10 ack while idle ignored", 0, 0, 0);

    // R4 masking by cpu priority, enable and priority 0
    cfg(7, 1, 2); cpu_prio = 2; irq_req[7] = 1;
    expect_tick("R4 prio equal to cpu masked", 0, 0, 0);
    cpu_prio = 1;
    expect_tick("R4 released when cpu prio drops", 1, 15, 2);
    ack = 1;
    expect_tick("R10 src7 retired", 0, 0, 0);
    cpu_prio = 0; cfg(9, 0, 5); irq_req[9] = 1;
    expect_tick("R4 disabled source hidden", 0, 0, 0);
    cfg(9, 1, 5);
    expect_tick("R4 enabled pending source shown", 1, 17, 5);
    ack = 1;
    expect_tick("R10 src9 retired", 0, 0, 0);
    cfg(10, 1, 0); irq_req[10] = 1;
    expect_tick("R4 priority 0 never shown", 0, 0, 0);
    cfg(10, 1, 4);
    expect_tick("R4 src10 shown at prio 4", 1, 18, 4);
    ack = 1;
    expect_tick("R10 src10 retired", 0, 0, 0);

    // R5 level beats position
    cfg(2, 1, 3); cfg(100, 1, 6); irq_req[2] = 1; irq_req[100] = 1;
    expect_tick("R5 higher level wins", 1, 108, 6);
    ack = 1;
    expect_tick("R5 lower level next", 1, 10, 3);
    ack = 1;
    expect_tick("R10 both retired", 0, 0, 0);

    // R6 ties
    cfg(40, 1, 4); cfg(20, 1, 4); irq_req[40] = 1; irq_req[20] = 1;
    expect_tick("R6 lower vector wins tie", 1, 28, 4);
    ack = 1;
    expect_tick("R6 higher vector next", 1, 48, 4);
    ack = 1;
    expect_tick("R6 drained", 0, 0, 0);

    // R2 trap vs source, cpu at 7
    cpu_prio = 7; cfg(3, 1, 7); irq_req[3] = 1; trap_req[5] = 1;
    expect_tick("R2 trap ignores cpu prio", 1, 5, 10);
    ack = 1;
    expect_tick("R2 source prio 7 masked at cpu 7", 0, 0, 0);
    cpu_prio = 6;
    expect_tick("R4 src3 shown at cpu 6", 1, 11, 7);
    ack = 1;
    expect_tick("R10 src3 retired", 0, 0, 0);
    cfg(30, 1, 7); irq_req[30] = 1; trap_req[7] = 1;
    expect_tick("R2 lowest trap beats top source", 1, 7, 8);
    ack = 1;
    expect_tick("R2 source follows trap", 1, 38, 7);
    ack = 1;
    expect_tick("R2 drained", 0, 0, 0);

    // R3 / R9 trap order
    trap_req[6] = 1; trap_req[1] = 1;
    expect_tick("R3 trap1 first R9 level 14", 1, 1, 14);
    ack = 1;
    expect_tick("R3 trap6 next R9 level 9", 1, 6, 9);
    ack = 1;
    expect_tick("R3 drained", 0, 0, 0);

    // R8 alternate table
    alt_sel = 1; cpu_prio = 0; cfg(117, 1, 1); irq_req[117] = 1;
    expect_tick("R8 last source alt address R11", 1, 125, 1);
    ack = 1;
    expect_tick("R8 drained", 0, 0, 0);
    trap_req[0] = 1;
    expect_tick("R8 trap0 alt base", 1, 0, 15);
    ack = 1;
    expect_tick("R8 trap0 retired", 0, 0, 0);
    alt_sel = 0;
    cfg(0, 1, 2); irq_req[0] = 1;
    expect_tick("R7 src0 primary R11", 1, 8, 2);
    ack = 1;
    expect_tick("R7 drained", 0, 0, 0);

    // R12 set wins over clear
    cfg(50, 1, 2); irq_req[50] = 1;
    expect_tick("R12 src50 shown", 1, 58, 2);
    ack = 1; irq_req[50] = 1;
    expect_tick("R12 re-request during ack stays pending", 1, 58, 2);
    ack = 1;
    expect_tick("R12 retired", 0, 0, 0);

    wait (sb.size() == 0);
    #1;
  endtask

  initial begin
    fork
      scenarios();
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule